// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from power-on to a usable state. Once synchronous reset is released it raises the clock enable and waits out the stabilization time. It then closes every bank, runs a train of auto-refresh cycles and programs the mode register. Every gap between those commands is counted in memory clock cycles and set by a parameter, so one implementation serves different clock rates and device grades. The defaults assume a 100 MHz memory clock.

When the mode register has settled, the block pulses a one-cycle load strobe that hands the refresh interval from its count input to the periodic refresh timer. The next cycle it raises `init_done`, and `init_done` stays high until the next reset. From then on the command pins idle at NOP, and the rest of the memory controller takes over the bus. All outputs are registered.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst` is high, and after the first clock edge following it, `cke_o` is 0, the command pins show NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111), `addr_o` and `ba_o` are 0, and `refi_load_o` and `init_done_o` are 0.
- R2: At the first clock edge with `rst` low, `cke_o` rises with the command pins at NOP, and it stays high until the next reset.
- R3: No command other than NOP appears until `T_WAIT` cycles after `cke_o` rose (default 10,000 cycles, which is 100 µs at 100 MHz).
- R4: Exactly one precharge-all (code 0010) is issued, exactly `T_WAIT` cycles after `cke_o` rose, with `addr_o[10]` = 1.
- R5: Exactly `N_REF` (default 8) auto-refresh commands (code 0001) follow. The first comes `T_RP` cycles after the precharge, and each later one comes `T_RC` cycles after the one before it.
- R6: One load-mode command (code 0000) comes `T_RC` cycles after the last refresh, with `ba_o` = 0 and `addr_o` = 0x220. That value means burst length 1 in bits 2:0 = 000, sequential in bit 3 = 0, CAS latency 2 in bits 6:4 = 010, standard mode in bits 8:7 = 00, single-location writes in bit 9 = 1, and the upper bits are 0.
- R7: `T_MRD` cycles after the load-mode command, `refi_load_o` is high for exactly one cycle, and `refi_val_o` carries the value of `refi_cnt_i` from that cycle.
- R8: `init_done_o` rises one cycle after the load strobe and stays high. After that the command pins stay at NOP, and `refi_val_o` keeps its captured value whatever `refi_cnt_i` does.
- R9: In every cycle not named in R4 to R6 the command pins show NOP, so exactly `N_REF`+2 non-NOP commands appear per sequence.
- R10: A synchronous reset at any point of the sequence returns all outputs to the R1 state at the next edge, and the next release restarts the whole sequence from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| refi_cnt_i | input | REFI_W | Refresh interval to hand to the refresh timer |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address lines (A10 and mode word) |
| refi_load_o | output | 1 | One-cycle strobe that loads the refresh timer |
| refi_val_o | output | REFI_W | Refresh interval captured at the strobe |
| init_done_o | output | 1 | Initialization complete |

## Verification
The assertions assume that `rst` is held high from time zero through at least one clock edge. They also assume that the parameters keep every gap at one cycle or more, that `T_WAIT` is at least as large as the other gaps, and that `ADDR_W` is at least 11. No other input affects when commands are issued. The stimulus keeps within these limits by holding reset for three cycles before every run and by leaving the parameters at their default values. It then varies only `refi_cnt_i` (random values, plus all-zeros and all-ones) and the cycle at which a mid-sequence reset is applied (random points before and inside the refresh train).

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_LMR = 4'b0000
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_REF,
    ST_MRS,
    ST_LOAD,
    ST_DONE
  } seq_st_e;

  // Mode word assembled from its fields
  function automatic logic [9:0] mrs_word(input logic [2:0] burst_len,
                                          input logic       burst_interleave,
                                          input logic [2:0] cas_lat,
                                          input logic [1:0] op_mode,
                                          input logic       single_write);
    return {single_write, op_mode, cas_lat, burst_interleave, burst_len};
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_pwrup_timer.sv
module sdram_pwrup_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_pwrup_drive.sv
module sdram_pwrup_drive
  import sdram_pwrup_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int REFI_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  sd_cmd_e           cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cke_set,
  input  logic              refi_ld,
  input  logic [REFI_W-1:0] refi_in,
  input  logic              done_in,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              refi_load_o,
  output logic [REFI_W-1:0] refi_val_o,
  output logic              init_done_o
);
  logic              cke_q, load_q, done_q;
  logic [3:0]        pins_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REFI_W-1:0] refi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q  <= 1'b0;
      pins_q <= CMD_NOP;
      addr_q <= '0;
      load_q <= 1'b0;
      refi_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (cke_set) cke_q <= 1'b1;
      pins_q <= cmd;
      addr_q <= addr;
      load_q <= refi_ld;
      if (refi_ld) refi_q <= refi_in;
      done_q <= done_in;
    end
  end

  assign cke_o       = cke_q;
  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins_q;
  assign ba_o        = '0;
  assign addr_o      = addr_q;
  assign refi_load_o = load_q;
  assign refi_val_o  = refi_q;
  assign init_done_o = done_q;
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_pwrup_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int REFI_W = 13,
  parameter int T_WAIT = 10000,
  parameter int T_RP   = 2,
  parameter int T_RC   = 7,
  parameter int T_MRD  = 2,
  parameter int N_REF  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REFI_W-1:0] refi_cnt_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              refi_load_o,
  output logic [REFI_W-1:0] refi_val_o,
  output logic              init_done_o
);
  localparam int GAP_MAX = max_of(max_of(T_WAIT, T_RC), max_of(T_RP, T_MRD));
  localparam int CNT_W   = $clog2(GAP_MAX + 1);
  localparam int REF_W   = $clog2(N_REF + 1);
  localparam logic [9:0] MODE_WORD = mrs_word(3'b000, 1'b0, 3'b010, 2'b00, 1'b1);

  seq_st_e           st_q, st_d;
  logic [REF_W-1:0]  ref_q, ref_d;
  logic              act_fire;   // gap timer has run out: current step may act
  logic              gap_ld;
  logic [CNT_W-1:0]  gap_val;
  sd_cmd_e           cmd;
  logic [ADDR_W-1:0] addr_c;
  logic              cke_set, refi_ld, done_now;

  sdram_pwrup_timer #(.CNT_W(CNT_W)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (gap_ld),
    .load_val (gap_val),
    .expired  (act_fire)
  );

  always_comb begin
    st_d    = st_q;
    ref_d   = ref_q;
    cmd     = CMD_NOP;
    addr_c  = '0;
    cke_set = 1'b0;
    refi_ld = 1'b0;
    gap_val = '0;
    if (act_fire) begin
      unique case (st_q)
        ST_IDLE: begin
          cke_set = 1'b1;
          gap_val = CNT_W'(T_WAIT - 1);
          st_d    = ST_PRE;
        end
        ST_PRE: begin
          cmd        = CMD_PRE;
          addr_c[10] = 1'b1;
          gap_val    = CNT_W'(T_RP - 1);
          ref_d      = '0;
          st_d       = ST_REF;
        end
        ST_REF: begin
          cmd     = CMD_REF;
          gap_val = CNT_W'(T_RC - 1);
          if (ref_q == REF_W'(N_REF - 1)) st_d = ST_MRS;
          else                            ref_d = ref_q + 1'b1;
        end
        ST_MRS: begin
          cmd     = CMD_LMR;
          addr_c  = ADDR_W'(MODE_WORD);
          gap_val = CNT_W'(T_MRD - 1);
          st_d    = ST_LOAD;
        end
        ST_LOAD: begin
          refi_ld = 1'b1;
          st_d    = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign gap_ld   = act_fire && (st_q != ST_DONE);
  assign done_now = (st_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      ref_q <= '0;
    end else begin
      st_q  <= st_d;
      ref_q <= ref_d;
    end
  end

  sdram_pwrup_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W), .REFI_W(REFI_W)) u_drv (
    .clk         (clk),
    .rst         (rst),
    .cmd         (cmd),
    .addr        (addr_c),
    .cke_set     (cke_set),
    .refi_ld     (refi_ld),
    .refi_in     (refi_cnt_i),
    .done_in     (done_now),
    .cke_o       (cke_o),
    .cs_n_o      (cs_n_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .we_n_o      (we_n_o),
    .ba_o        (ba_o),
    .addr_o      (addr_o),
    .refi_load_o (refi_load_o),
    .refi_val_o  (refi_val_o),
    .init_done_o (init_done_o)
  );
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int T_WAIT = 10000,
  parameter int N_REF  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              refi_load,
  input logic              init_done,
  input logic              act_fire
);
  logic [3:0] pins;
  int unsigned wait_cnt;
  int unsigned ref_cnt;
  assign pins = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= 0;
      ref_cnt  <= 0;
    end else begin
      if (cke && wait_cnt < T_WAIT) wait_cnt <= wait_cnt + 1;
      if (pins == 4'b0001) ref_cnt <= ref_cnt + 1;
    end
  end

  a_r2_cke_sticky: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);
  a_r3_no_early_cmd: assert property (@(posedge clk) disable iff (rst)
    (pins != 4'b0111) |-> (cke && wait_cnt >= T_WAIT));
  a_r4_pre_a10: assert property (@(posedge clk) disable iff (rst)
    (pins == 4'b0010) |-> addr[10]);
  a_r5_ref_bound: assert property (@(posedge clk) disable iff (rst)
    (pins == 4'b0001) |-> (ref_cnt < N_REF));
  a_r6_lmr_after_refs: assert property (@(posedge clk) disable iff (rst)
    (pins == 4'b0000) |-> (ref_cnt == N_REF && ba == '0 && addr == ADDR_W'(10'h220)));
  a_r7_load_single: assert property (@(posedge clk) disable iff (rst)
    refi_load |=> !refi_load);
  a_r8_done_after_load: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> $past(refi_load));
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (pins == 4'b0111));
  a_r9_nop_while_waiting: assert property (@(posedge clk) disable iff (rst)
    !act_fire |=> (pins == 4'b0111));
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .T_WAIT(T_WAIT), .N_REF(N_REF)
) u_chk (
  .clk(clk), .rst(rst), .cke(cke_o), .cs_n(cs_n_o), .ras_n(ras_n_o),
  .cas_n(cas_n_o), .we_n(we_n_o), .ba(ba_o), .addr(addr_o),
  .refi_load(refi_load_o), .init_done(init_done_o), .act_fire(act_fire)
);

// File: tb/sdram_pwrup_seq_bench.sv
module sdram_pwrup_seq_bench;
  localparam int ADDR_W = 12;
  localparam int BA_W   = 2;
  localparam int REFI_W = 13;
  localparam int T_WAIT = 10000;
  localparam int T_RP   = 2;
  localparam int T_RC   = 7;
  localparam int T_MRD  = 2;
  localparam int N_REF  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [REFI_W-1:0] refi_cnt_i = '0;
  logic              cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [BA_W-1:0]   ba_o;
  logic [ADDR_W-1:0] addr_o;
  logic              refi_load_o, init_done_o;
  logic [REFI_W-1:0] refi_val_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdram_pwrup_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .REFI_W(REFI_W), .T_WAIT(T_WAIT),
    .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .N_REF(N_REF)
  ) u_sdram_pwrup_seq (
    .clk(clk), .rst(rst), .refi_cnt_i(refi_cnt_i), .cke_o(cke_o),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o), .refi_load_o(refi_load_o),
    .refi_val_o(refi_val_o), .init_done_o(init_done_o)
  );

  // expected edge index (1 = first edge with rst low) of each event
  function automatic int exp_pre();  return 1 + T_WAIT; endfunction
  function automatic int exp_ref(input int i); return exp_pre() + T_RP + i * T_RC; endfunction
  function automatic int exp_lmr();  return exp_ref(N_REF - 1) + T_RC; endfunction
  function automatic int exp_load(); return exp_lmr() + T_MRD; endfunction
  function automatic int exp_mode();
    return (0 << 0) | (0 << 3) | (2 << 4) | (0 << 7) | (1 << 9);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(cke_o == 1'b0, {req, " cke low"}, cke_o, 0);
    chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111, {req, " NOP"},
        {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 7);
    chk(addr_o == '0 && ba_o == '0, {req, " addr/ba zero"}, addr_o, 0);
    chk(!refi_load_o && !init_done_o, {req, " load/done low"},
        {refi_load_o, init_done_o}, 0);
  endtask

  // abort_at = 0 runs to completion; otherwise reset is applied after that edge
  task automatic run_seq(input logic [REFI_W-1:0] refi, input int abort_at);
    int cke_at = 0, pre_at = 0, n_pre = 0, n_ref = 0, lmr_at = 0, n_lmr = 0;
    int load_at = 0, n_load = 0, done_at = 0, n_cmd = 0, lmr_addr = 0, lmr_ba = 0;
    int bad_a10 = 0, cke_drop = 0;
    int ref_at[16];
    logic [REFI_W-1:0] got_refi = '0;
    logic [REFI_W-1:0] held;
    for (int i = 0; i < 16; i++) ref_at[i] = 0;
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R1 reset state");
    refi_cnt_i = refi;
    rst = 1'b0;
    for (int k = 1; k < T_WAIT + 200; k++) begin
      @(negedge clk);
      if (cke_o && cke_at == 0) begin
        cke_at = k;
        if (k == 1)
          chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111, "R2 NOP with cke rise",
              {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 7);
      end
      if (!cke_o && cke_at != 0) cke_drop++;
      case ({cs_n_o, ras_n_o, cas_n_o, we_n_o})
        4'b0111: ;
        4'b0010: begin n_pre++; n_cmd++; pre_at = k; if (!addr_o[10]) bad_a10++; end
        4'b0001: begin if (n_ref < 16) ref_at[n_ref] = k; n_ref++; n_cmd++; end
        4'b0000: begin n_lmr++; n_cmd++; lmr_at = k; lmr_addr = int'(addr_o); lmr_ba = int'(ba_o); end
        default: n_cmd++;
      endcase
      if (refi_load_o) begin n_load++; load_at = k; got_refi = refi_val_o; end
      if (init_done_o && done_at == 0) done_at = k;
      if (abort_at != 0 && k == abort_at) break;
      if (done_at != 0 && k >= done_at + 2) break;
    end
    if (abort_at != 0) begin
      @(negedge clk) rst = 1'b1;
      @(negedge clk);
      chk_idle("R10 reset mid-sequence");
      return;
    end
    chk(cke_at == 1, "R2 cke rise edge", cke_at, 1);
    chk(cke_drop == 0, "R2 cke stays high", cke_drop, 0);
    chk(pre_at == exp_pre(), "R3 wait before precharge", pre_at, exp_pre());
    chk(n_pre == 1 && bad_a10 == 0, "R4 single precharge with A10", n_pre, 1);
    chk(n_ref == N_REF, "R5 refresh count", n_ref, N_REF);
    for (int i = 0; i < N_REF; i++)
      chk(ref_at[i] == exp_ref(i), "R5 refresh timing", ref_at[i], exp_ref(i));
    chk(n_lmr == 1 && lmr_at == exp_lmr(), "R6 load-mode timing", lmr_at, exp_lmr());
    chk(lmr_addr == exp_mode(), "R6 mode word", lmr_addr, exp_mode());
    chk(lmr_ba == 0, "R6 bank address", lmr_ba, 0);
    chk(n_load == 1 && load_at == exp_load(), "R7 load strobe timing", load_at, exp_load());
    chk(got_refi == refi, "R7 captured interval", int'(got_refi), int'(refi));
    chk(done_at == exp_load() + 1, "R8 done timing", done_at, exp_load() + 1);
    chk(n_cmd == N_REF + 2, "R9 non-NOP command count", n_cmd, N_REF + 2);
    held = refi;
    refi_cnt_i = ~refi;
    repeat (20) begin
      @(negedge clk);
      if (!init_done_o || {cs_n_o, ras_n_o, cas_n_o, we_n_o} != 4'b0111 ||
          refi_val_o != held || refi_load_o) begin
        chk(1'b0, "R8 idle after done", int'(refi_val_o), int'(held));
      end
    end
    chk(refi_val_o == held && init_done_o, "R8 interval held", int'(refi_val_o), int'(held));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk);
    chk_idle("R1 power-on");
    run_seq(REFI_W'(1539), 0);
    run_seq(REFI_W'($urandom % (T_WAIT / 2) + 1), 0);
    run_seq(REFI_W'(5), T_WAIT + T_RP + 3 * T_RC);
    run_seq('1, 0);
    run_seq(REFI_W'($urandom), int'($urandom % T_WAIT) + 1);
    run_seq('0, 1);
    run_seq(REFI_W'($urandom), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule